// File: doc/BRIEF.md
# Accumulator Processor Sequencer

This block is a small processor core with one accumulator. A multi-cycle state machine runs each instruction in a fixed series of steps. It fetches a 16-bit word from a synchronous single-port memory and decodes the opcode in the top four bits. It then resolves the operand, which may need one extra memory read to follow a pointer, and finally executes the instruction and moves the program counter on. The core has a 16-bit input port that the program can sample, a 16-bit output port with a one-clock strobe, and a halt indication that holds until reset.

The low twelve bits of each instruction word form its address field. For the memory-operand instructions (LOAD, STORE, ADD, SUB, AND), the top bit of that field selects indirect mode. In indirect mode the eleven bits below it name a pointer word, and the low twelve bits of that pointer give the real operand location. Jumps use all twelve bits as the target.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and after it is released, halted, out_valid and mem_we are 0 and out_data is 0. The program counter and accumulator start at 0, so the first instruction is fetched from address 0.
- R2: Bits 15:12 of an instruction word hold the opcode and bits 11:0 hold the address field. The opcodes are 0 HALT, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 JMP, 6 JZ, 7 IN, 8 OUT, 9 AND and A NOT.
- R3: Memory reads have one clock of latency. The core presents an address in one state and latches mem_rdata in the next state.
- R4: A direct LOAD copies the word at its address field into the accumulator. A direct LOAD followed by a HALT at address 1 asserts halted on the 12th rising edge after reset is released.
- R5: With bit 11 set, LOAD, STORE, ADD, SUB and AND first read the word at address bits 10:0 and use its bits 11:0 as the operand address. This costs exactly two extra clocks, and the pointer word is left unchanged.
- R6: STORE writes the accumulator to its operand address with mem_we high for exactly one clock.
- R7: ADD, SUB and AND combine the accumulator with the operand modulo 2^16, and NOT inverts the accumulator.
- R8: After each instruction the program counter advances by one. JMP loads it with all twelve address bits, and JZ does the same only when the accumulator is zero.
- R9: IN copies the input port into the accumulator. OUT places the accumulator on out_data and raises out_valid for exactly one clock per OUT.
- R10: HALT sets halted. From then until reset there are no writes, no output strobes and no change on mem_addr.
- R11: Opcodes B through F change no state other than advancing the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data (accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| in_data | input | 16 | Input port sampled by IN |
| out_data | output | 16 | Output register written by OUT |
| out_valid | output | 1 | One-clock strobe on each OUT |
| halted | output | 1 | High once HALT has executed |

## Verification
The hardest case to reach from the ports is the indirect path through a pointer word. Proving that the pointer is followed, and that the pointer itself is neither overwritten nor used as data, needs a program in which a pointer and its target hold different values. That program includes an indirect STORE whose pointer location is checked afterwards. Bit 11 has two meanings. Its double role is tested by jumping to an address with bit 11 set, which has to take the jump rather than enter indirect mode. The microcycle count is pinned down by counting clocks from reset release to halt for a direct LOAD and for an indirect LOAD.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
   localparam logic [OPC_W-1:0] OPC_ADD   = 4'h3;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'h4;
   localparam logic [OPC_W-1:0] OPC_JMP   = 4'h5;
   localparam logic [OPC_W-1:0] OPC_JZ    = 4'h6;
   localparam logic [OPC_W-1:0] OPC_IN    = 4'h7;
   localparam logic [OPC_W-1:0] OPC_OUT   = 4'h8;
   localparam logic [OPC_W-1:0] OPC_AND   = 4'h9;
   localparam logic [OPC_W-1:0] OPC_NOT   = 4'hA;

   typedef enum logic [3:0] {
      S_FMAR, S_FRD, S_FLAT, S_DEC,
      S_IRD,  S_ILAT,
      S_ORD,  S_OLAT,
      S_STW,  S_EXEC, S_HALT
   } cpu_state_e;

   function automatic logic is_mem_op(input logic [OPC_W-1:0] op);
      return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_ADD) ||
             (op == OPC_SUB)  || (op == OPC_AND);
   endfunction
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] dec_op,
   input  logic             dec_ind,
   input  logic [OPC_W-1:0] opc,
   output cpu_state_e       state
);
   cpu_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         S_FMAR: nxt = S_FRD;
         S_FRD:  nxt = S_FLAT;
         S_FLAT: nxt = S_DEC;
         S_DEC: begin
            if (is_mem_op(dec_op) && dec_ind) nxt = S_IRD;
            else if (dec_op == OPC_STORE)     nxt = S_STW;
            else if (is_mem_op(dec_op))       nxt = S_ORD;
            else                              nxt = S_EXEC;
         end
         S_IRD:  nxt = S_ILAT;
         S_ILAT: nxt = (opc == OPC_STORE) ? S_STW : S_ORD;
         S_ORD:  nxt = S_OLAT;
         S_OLAT: nxt = S_EXEC;
         S_STW:  nxt = S_EXEC;
         S_EXEC: nxt = (opc == OPC_HALT) ? S_HALT : S_FMAR;
         S_HALT: nxt = S_HALT;
         default: nxt = S_FMAR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= S_FMAR;
      else        state <= nxt;
   end

   // R3: a latch state is only ever entered from its matching request state
   p_read_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_OLAT) |-> $past(state == S_ORD));
   // R5: the pointer latch follows the pointer request
   p_ptr_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_ILAT) |-> $past(state == S_IRD));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic [OPC_W-1:0]  op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] inr,
   output logic [DATA_W-1:0] result,
   output logic              acc_wr
);
   always_comb begin
      result = acc;
      acc_wr = 1'b1;
      unique case (op)
         OPC_LOAD: result = operand;
         OPC_ADD:  result = acc + operand;
         OPC_SUB:  result = acc - operand;
         OPC_AND:  result = acc & operand;
         OPC_NOT:  result = ~acc;
         OPC_IN:   result = inr;
         default:  acc_wr = 1'b0;
      endcase
   end
endmodule

// File: rtl/acc_regs.sv
module acc_regs
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter bit IND_EN = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  cpu_state_e              state,
   input  logic [DATA_W-1:0]       mem_rdata,
   input  logic [DATA_W-1:0]       in_data,
   output logic [DATA_W-OPC_W-1:0] mem_addr,
   output logic [DATA_W-1:0]       mem_wdata,
   output logic                    mem_we,
   output logic [OPC_W-1:0]        dec_op,
   output logic                    dec_ind,
   output logic [OPC_W-1:0]        opc,
   output logic [DATA_W-1:0]       out_data,
   output logic                    out_valid,
   output logic                    halted
);
   localparam int ADDR_W = DATA_W - OPC_W;

   logic [ADDR_W-1:0] pc, mar;
   logic [DATA_W-1:0] acc, mdr, inr, alu_res;
   logic [ADDR_W-1:0] dec_addr, field;
   logic              alu_wr, take_jump;

   assign field  = mdr[ADDR_W-1:0];
   assign dec_op = mdr[DATA_W-1 -: OPC_W];

   generate
      if (IND_EN) begin : g_ind
         assign dec_ind  = is_mem_op(dec_op) & field[ADDR_W-1];
         assign dec_addr = is_mem_op(dec_op) ? {1'b0, field[ADDR_W-2:0]} : field;
      end else begin : g_dir
         assign dec_ind  = 1'b0;
         assign dec_addr = field;
      end
   endgenerate

   acc_alu #(.DATA_W(DATA_W)) u_alu (
      .op(opc), .acc(acc), .operand(mdr), .inr(inr),
      .result(alu_res), .acc_wr(alu_wr)
   );

   assign take_jump = (opc == OPC_JMP) || ((opc == OPC_JZ) && (acc == '0));
   assign mem_addr  = mar;
   assign mem_wdata = acc;
   assign mem_we    = (state == S_STW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0; mar <= '0; acc <= '0; mdr <= '0; opc <= OPC_HALT;
         inr <= '0; out_data <= '0; out_valid <= 1'b0; halted <= 1'b0;
      end else begin
         inr       <= in_data;
         out_valid <= 1'b0;
         unique case (state)
            S_FMAR: mar <= pc;
            S_FLAT: mdr <= mem_rdata;
            S_DEC: begin
               opc <= dec_op;
               mar <= dec_addr;
            end
            S_ILAT: mar <= mem_rdata[ADDR_W-1:0];
            S_OLAT: mdr <= mem_rdata;
            S_EXEC: begin
               if (alu_wr) acc <= alu_res;
               if (opc == OPC_OUT) begin
                  out_data  <= acc;
                  out_valid <= 1'b1;
               end
               if (opc == OPC_HALT) halted <= 1'b1;
               else if (take_jump)  pc <= mar;
               else                 pc <= pc + 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R6: a store drives the write enable for a single clock
   p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);
   // R9: the output strobe never lasts two clocks
   p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R10: once halted the core stays halted with a frozen address
   p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(mem_addr) && !mem_we && !out_valid));
   // R8: the program counter moves only at the end of an instruction
   p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_EXEC) |=> $stable(pc));
   // R7: the accumulator changes only in the execute step
   p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_EXEC) |=> $stable(acc));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter bit IND_EN = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   output logic [DATA_W-OPC_W-1:0] mem_addr,
   output logic [DATA_W-1:0]       mem_wdata,
   output logic                    mem_we,
   input  logic [DATA_W-1:0]       mem_rdata,
   input  logic [DATA_W-1:0]       in_data,
   output logic [DATA_W-1:0]       out_data,
   output logic                    out_valid,
   output logic                    halted
);
   generate
      if (DATA_W < OPC_W + 2) begin : g_bad_width
         $error("acc_cpu: DATA_W must leave at least two address bits");
      end
   endgenerate

   cpu_state_e       state;
   logic [OPC_W-1:0] dec_op, opc;
   logic             dec_ind;

   acc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .dec_op(dec_op), .dec_ind(dec_ind),
      .opc(opc), .state(state)
   );

   acc_regs #(.DATA_W(DATA_W), .IND_EN(IND_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .state(state), .mem_rdata(mem_rdata),
      .in_data(in_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .dec_op(dec_op), .dec_ind(dec_ind), .opc(opc),
      .out_data(out_data), .out_valid(out_valid), .halted(halted)
   );
endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata, in_data, out_data;
   logic        mem_we, out_valid, halted;

   logic [15:0] mem [0:4095];
   logic [15:0] outs [0:15];
   int          n_outs, n_writes, checks, errors, cyc_total;

   always #2.5 clk = ~clk;

   acc_cpu dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
      .out_data(out_data), .out_valid(out_valid), .halted(halted)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   always @(negedge clk) begin
      cyc_total++;
      if (rst_n) begin
         if (out_valid) begin
            if (n_outs < 16) outs[n_outs] = out_data;
            n_outs++;
         end
         if (mem_we) n_writes++;
      end
      if (cyc_total > 150000) begin
         errors++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc_total);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
      return {op, a};
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
   endtask

   task automatic boot();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      n_outs = 0;
      n_writes = 0;
      rst_n = 1'b1;
   endtask

   task automatic run(output int cyc);
      cyc = 0;
      while (!halted && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   // R1: reset state at the ports
   task automatic t_reset();
      int cyc;
      clear_mem();
      in_data = 16'h0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(halted == 1'b0, "R1 halted in reset", halted, 0);
      chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      chk(mem_we == 1'b0, "R1 mem_we in reset", mem_we, 0);
      chk(out_data == 16'h0, "R1 out_data in reset", out_data, 0);
      mem[0] = ins(4'h8, 12'h0);
      mem[1] = ins(4'h0, 12'h0);
      boot();
      run(cyc);
      chk(n_outs == 1 && outs[0] == 16'h0, "R1 accumulator starts at zero", outs[0], 0);
   endtask

   // R2 R4 R6 R7: direct arithmetic and store
   task automatic t_direct();
      int cyc;
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h3, 12'h101);
      mem[2] = ins(4'h2, 12'h102);
      mem[3] = ins(4'h4, 12'h103);
      mem[4] = ins(4'h8, 12'h000);
      mem[5] = ins(4'h0, 12'h000);
      mem[12'h100] = 16'h1234;
      mem[12'h101] = 16'h0F0F;
      mem[12'h103] = 16'h3000;
      boot();
      run(cyc);
      chk(mem[12'h102] == 16'h2143, "R6 store of LOAD+ADD", mem[12'h102], 16'h2143);
      chk(n_writes == 1, "R6 one write cycle", n_writes, 1);
      chk(outs[0] == 16'hF143, "R7 SUB wraps modulo 2^16", outs[0], 16'hF143);
      chk(halted == 1'b1, "R2 HALT opcode 0 decoded", halted, 1);
   endtask

   // R4 R3 R5: microcycle counts
   task automatic t_timing();
      int cyc;
      clear_mem();
      mem[0] = ins(4'h1, 12'h050);
      mem[1] = ins(4'h0, 12'h000);
      mem[12'h050] = 16'hA5A5;
      boot();
      run(cyc);
      chk(cyc == 12, "R4 direct LOAD+HALT clocks", cyc, 12);
      clear_mem();
      mem[0] = ins(4'h1, 12'h850);
      mem[1] = ins(4'h0, 12'h000);
      mem[12'h050] = 16'h0060;
      boot();
      run(cyc);
      chk(cyc == 14, "R5 indirect LOAD+HALT clocks", cyc, 14);
   endtask

   // R5: pointer following for LOAD, AND, ADD, STORE
   task automatic t_indirect();
      int cyc;
      clear_mem();
      mem[0] = ins(4'h1, 12'h810);
      mem[1] = ins(4'h9, 12'h811);
      mem[2] = ins(4'h3, 12'h813);
      mem[3] = ins(4'h8, 12'h000);
      mem[4] = ins(4'h2, 12'h812);
      mem[5] = ins(4'h1, 12'h010);
      mem[6] = ins(4'h8, 12'h000);
      mem[7] = ins(4'h0, 12'h000);
      mem[12'h010] = 16'h0200;
      mem[12'h011] = 16'h0201;
      mem[12'h012] = 16'h0300;
      mem[12'h013] = 16'h0202;
      mem[12'h200] = 16'h0055;
      mem[12'h201] = 16'h00F0;
      mem[12'h202] = 16'h0001;
      boot();
      run(cyc);
      chk(outs[0] == 16'h0051, "R5 indirect LOAD/AND/ADD", outs[0], 16'h0051);
      chk(mem[12'h300] == 16'h0051, "R5 indirect STORE target", mem[12'h300], 16'h0051);
      chk(mem[12'h012] == 16'h0300, "R5 pointer word untouched", mem[12'h012], 16'h0300);
      chk(outs[1] == 16'h0200, "R5 bit11 clear reads pointer as data", outs[1], 16'h0200);
   endtask

   // R8: JZ taken / not taken, JMP with bit 11 set
   task automatic t_jumps();
      int cyc;
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'h6, 12'h004);
      mem[2] = ins(4'h8, 12'h000);
      mem[3] = ins(4'h0, 12'h000);
      mem[4] = ins(4'h1, 12'h101);
      mem[5] = ins(4'h6, 12'h00A);
      mem[6] = ins(4'h8, 12'h000);
      mem[7] = ins(4'h5, 12'h800);
      mem[8] = ins(4'h8, 12'h000);
      mem[12'h800] = ins(4'hA, 12'h000);
      mem[12'h801] = ins(4'h8, 12'h000);
      mem[12'h802] = ins(4'h0, 12'h000);
      mem[12'h100] = 16'h0000;
      mem[12'h101] = 16'h0005;
      boot();
      run(cyc);
      chk(n_outs == 2, "R8 skipped instructions", n_outs, 2);
      chk(outs[0] == 16'h0005, "R8 JZ not taken falls through", outs[0], 16'h0005);
      chk(outs[1] == 16'hFFFA, "R8 JMP to 0x800 then NOT", outs[1], 16'hFFFA);
   endtask

   // R9: input port and output strobe
   task automatic t_io();
      int cyc;
      clear_mem();
      mem[0] = ins(4'h7, 12'h000);
      mem[1] = ins(4'h8, 12'h000);
      mem[2] = ins(4'h8, 12'h000);
      mem[3] = ins(4'h0, 12'h000);
      in_data = 16'hBEEF;
      boot();
      run(cyc);
      chk(n_outs == 2, "R9 one strobe cycle per OUT", n_outs, 2);
      chk(outs[0] == 16'hBEEF && outs[1] == 16'hBEEF, "R9 IN value on out_data", outs[0], 16'hBEEF);
   endtask

   // R10: halt is quiet and sticky until reset
   task automatic t_halt();
      int cyc;
      logic [11:0] a;
      logic quiet;
      clear_mem();
      mem[0] = ins(4'h0, 12'h000);
      mem[1] = ins(4'h8, 12'h000);
      mem[2] = ins(4'h2, 12'h005);
      boot();
      run(cyc);
      a = mem_addr;
      quiet = 1'b1;
      repeat (40) begin
         @(negedge clk);
         if (mem_we || out_valid || !halted || mem_addr != a) quiet = 1'b0;
      end
      chk(quiet, "R10 no activity while halted", quiet, 1);
      chk(n_outs == 0 && n_writes == 0, "R10 no OUT or STORE after HALT", n_outs + n_writes, 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk(halted == 1'b0, "R10 reset clears halt", halted, 1'b0);
   endtask

   // R11: undefined opcodes are no-ops
   task automatic t_undef();
      int cyc;
      clear_mem();
      mem[0] = ins(4'h1, 12'h100);
      mem[1] = ins(4'hB, 12'h123);
      mem[2] = ins(4'hF, 12'h800);
      mem[3] = ins(4'hC, 12'h000);
      mem[4] = ins(4'h8, 12'h000);
      mem[5] = ins(4'h0, 12'h000);
      mem[12'h100] = 16'h1111;
      mem[12'h123] = 16'h7777;
      boot();
      run(cyc);
      chk(outs[0] == 16'h1111, "R11 accumulator unchanged", outs[0], 16'h1111);
      chk(n_writes == 0 && mem[12'h123] == 16'h7777, "R11 no memory write", n_writes, 0);
      chk(halted == 1'b1, "R11 PC advanced to HALT", halted, 1);
   endtask

   initial begin
      checks = 0; errors = 0; cyc_total = 0; n_outs = 0; n_writes = 0;
      in_data = 16'h0;
      t_reset();
      t_direct();
      t_timing();
      t_indirect();
      t_jumps();
      t_io();
      t_halt();
      t_undef();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule